// File: doc/BRIEF.md
# Set-Associative Read Cache

This block is a parameterised N-way set-associative cache that serves reads on 32-bit byte addresses. It splits each request address into a tag, a set index and a byte offset. It compares the tag against every way of the indexed set at the same time. It then answers with a hit flag and the addressed data word. The tag and line storage is built as one synchronous-read RAM pair per way, and the valid bits are held in flip-flops.

On a miss the cache asks a simple block-wide memory port for the whole aligned line. When the line arrives, the cache writes it into the chosen way, sets that way's valid bit and returns the requested word from the incoming line. If the set still holds an invalid way, the lowest-numbered invalid way is filled and the miss is marked cold. If every way is valid, an external replacement-policy input picks the way to evict, and the miss is reported as a replacement.

A requester raises `req_valid` while `req_ready` is high. It then waits for the one-cycle `resp_valid` pulse before it can issue the next request.

Top module: `sa_read_cache`

## Requirements
- R1: An address splits into a byte offset in the low log2(BLOCK_BYTES) bits, a set index in the next log2(SETS) bits and a tag in the remaining upper bits. Two addresses with the same index but different tags therefore occupy different lines.
- R2: A lookup hits only when a single way of the indexed set is both valid and holds a matching tag. All ways are examined in parallel.
- R3: For a request accepted on clock edge k that hits, `resp_valid` and `resp_hit` are high for exactly one cycle after edge k+1, together with the addressed word on `resp_data`.
- R4: For a request accepted on edge k that misses, `mem_req_valid` rises after edge k+1 with the block-aligned address (offset bits zero). Both the request and the address hold steady until a cycle with `mem_resp_valid` high.
- R5: `req_ready` is low from the edge that accepts a request until the edge that produces its response, and is high again right after that edge.
- R6: A fill writes the whole aligned block, so a later access to another word of the same block hits.
- R7: A miss in a set that still has an invalid way fills the lowest-numbered invalid way and reports `resp_cold`=1.
- R8: A miss in a set whose ways are all valid replaces the way given on `victim_way` (sampled in the lookup cycle) and reports `resp_cold`=0.
- R9: A synchronous reset clears every valid bit, so the first access to any address after reset is a cold miss. Just after reset, `req_ready` is 1 and `resp_valid` and `mem_req_valid` are 0.
- R10: With 2 ways, 2 sets and 8-byte blocks, the byte accesses 4, 0, 8, 36, 0 give miss, hit, miss, miss, hit. Address 36 lands in set 0, way 1.
- R11: A miss completes on the edge that sees `mem_resp_valid`. Right after that edge, `resp_valid`=1 and `resp_hit`=0, and `resp_data` is the requested word taken from `mem_resp_data`, where word i of the line sits at bits [32*i +: 32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Cache can accept a request |
| victim_way | input | log2(WAYS) | Way to evict when the set is full |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from a hit |
| resp_cold | output | 1 | Miss filled a previously invalid way |
| resp_data | output | DATA_W | Requested word |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_addr | output | ADDR_W | Block-aligned fetch address |
| mem_resp_valid | input | 1 | Line data present |
| mem_resp_data | input | 8*BLOCK_BYTES | Whole line, word 0 in the low bits |

## Verification
A hit is due exactly two edges after acceptance: one edge to read the way RAMs, then one to register the compare result. The fetch request of a miss appears at that same second edge. The response of a miss follows on the edge that samples `mem_resp_valid`. The bench drives every input at a falling edge and counts rising edges from the accepting one. It samples the outputs at the falling edge after each due edge and also checks `req_ready` and `mem_req_valid` at every intermediate falling edge. A behavioural model holding per-set valid flags and tags predicts the hit, cold and data results. Memory latency and victim choice are varied per access.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } cache_state_e;
endpackage

// File: rtl/sa_cache_way_ram.sv
module sa_cache_way_ram #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [LINE_W-1:0] line_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_idx];
      rd_line <= line_mem[rd_idx];
    end
  end
endmodule

// File: rtl/sa_cache_match.sv
module sa_cache_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]       valid_vec,
  input  logic [TAG_W-1:0]      look_tag,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic                  any_free,
  output logic [WAY_W-1:0]      free_way
);
  logic [WAYS-1:0] eq_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq_vec[g] = valid_vec[g] && (way_tags[g*TAG_W +: TAG_W] == look_tag);
  end

  always_comb begin
    hit      = |eq_vec;
    any_free = ~&valid_vec;
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq_vec[w])     hit_way  = WAY_W'(w);
      if (!valid_vec[w]) free_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/sa_read_cache.sv
module sa_read_cache #(
  parameter int WAYS        = 4,
  parameter int SETS        = 64,
  parameter int BLOCK_BYTES = 16,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        req_ready,
  input  logic [$clog2(WAYS)-1:0]     victim_way,
  output logic                        resp_valid,
  output logic                        resp_hit,
  output logic                        resp_cold,
  output logic [DATA_W-1:0]           resp_data,
  output logic                        mem_req_valid,
  output logic [ADDR_W-1:0]           mem_req_addr,
  input  logic                        mem_resp_valid,
  input  logic [8*BLOCK_BYTES-1:0]    mem_resp_data
);
  import sa_cache_pkg::*;

  localparam int OFF_W      = $clog2(BLOCK_BYTES);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W      = $clog2(WAYS);
  localparam int LINE_W     = 8 * BLOCK_BYTES;
  localparam int BYTE_OFF_W = $clog2(DATA_W / 8);

  cache_state_e state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAY_W-1:0]  fill_way_q;
  logic              fill_cold_q;

  wire [TAG_W-1:0] tag_q   = addr_q[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] idx_q   = addr_q[OFF_W +: IDX_W];
  wire [OFF_W-1:0] off_q   = addr_q[OFF_W-1:0];
  wire [OFF_W-1:0] wsel    = off_q >> BYTE_OFF_W;
  wire [IDX_W-1:0] req_idx = req_addr[OFF_W +: IDX_W];

  wire accept  = req_valid && (state_q == ST_IDLE);
  wire fill_do = (state_q == ST_FILL) && mem_resp_valid;

  logic [WAYS*TAG_W-1:0]  rd_tags;
  logic [WAYS*LINE_W-1:0] rd_lines;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    sa_cache_way_ram #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
    ) u_ram (
      .clk    (clk),
      .wr_en  (fill_do && (fill_way_q == WAY_W'(g))),
      .wr_idx (idx_q),
      .wr_tag (tag_q),
      .wr_line(mem_resp_data),
      .rd_en  (accept),
      .rd_idx (req_idx),
      .rd_tag (rd_tags[g*TAG_W +: TAG_W]),
      .rd_line(rd_lines[g*LINE_W +: LINE_W])
    );
  end

  logic             look_hit;
  logic [WAY_W-1:0] look_way;
  logic             look_free;
  logic [WAY_W-1:0] look_free_way;

  sa_cache_match #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .WAY_W(WAY_W)
  ) u_match (
    .valid_vec(valid_q[idx_q]),
    .look_tag (tag_q),
    .way_tags (rd_tags),
    .hit      (look_hit),
    .hit_way  (look_way),
    .any_free (look_free),
    .free_way (look_free_way)
  );

  logic [LINE_W-1:0] hit_line;
  always_comb begin
    hit_line = rd_lines[LINE_W-1:0];
    for (int w = 0; w < WAYS; w++) begin
      if (look_way == WAY_W'(w)) hit_line = rd_lines[w*LINE_W +: LINE_W];
    end
  end

  wire [DATA_W-1:0] hit_word  = hit_line[int'(wsel)*DATA_W +: DATA_W];
  wire [DATA_W-1:0] fill_word = mem_resp_data[int'(wsel)*DATA_W +: DATA_W];

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      addr_q        <= '0;
      fill_way_q    <= '0;
      fill_cold_q   <= 1'b0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_cold     <= 1'b0;
      resp_data     <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (look_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_cold  <= 1'b0;
            resp_data  <= hit_word;
            state_q    <= ST_IDLE;
          end else begin
            fill_way_q    <= look_free ? look_free_way : victim_way;
            fill_cold_q   <= look_free;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            state_q       <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_resp_valid) begin
            valid_q[idx_q][fill_way_q] <= 1'b1;
            mem_req_valid <= 1'b0;
            resp_valid    <= 1'b1;
            resp_hit      <= 1'b0;
            resp_cold     <= fill_cold_q;
            resp_data     <= fill_word;
            state_q       <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_read_cache_chk.sv
module sa_read_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              resp_cold,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_resp_valid
);
  // R5: accepting a request drops ready on the next cycle
  a_r5_accept_busy: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R5: no new request while a line fetch is outstanding
  a_r5_busy_in_fill: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R4: fetch address is block aligned
  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R4: request holds with stable address until answered
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr));

  // R11: an answered fetch yields a miss response next cycle
  a_r11_fill_resp: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_resp_valid |=> resp_valid && !resp_hit && !mem_req_valid);

  // R3: response strobe lasts one cycle
  a_r3_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R7: a cold report is never a hit
  a_r7_cold_is_miss: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_cold |-> !resp_hit);
endmodule

bind sa_read_cache sa_read_cache_chk #(
  .ADDR_W(ADDR_W),
  .OFF_W (OFF_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .resp_valid    (resp_valid),
  .resp_hit      (resp_hit),
  .resp_cold     (resp_cold),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_resp_valid(mem_resp_valid)
);

// File: tb/sa_read_cache_tb.sv
module sa_read_cache_tb;
  localparam int WAYS = 2;
  localparam int SETS = 2;
  localparam int BB   = 8;
  localparam int NW   = BB / 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [31:0]       req_addr = '0;
  logic              req_ready;
  logic [0:0]        victim_way = '0;
  logic              resp_valid, resp_hit, resp_cold;
  logic [31:0]       resp_data;
  logic              mem_req_valid;
  logic [31:0]       mem_req_addr;
  logic              mem_resp_valid = 1'b0;
  logic [8*BB-1:0]   mem_resp_data = '0;

  int n_chk = 0;
  int n_err = 0;

  // behavioural model
  bit          m_val [SETS][WAYS];
  logic [31:0] m_tag [SETS][WAYS];

  always #5 clk = ~clk;

  sa_read_cache #(
    .WAYS(WAYS), .SETS(SETS), .BLOCK_BYTES(BB), .ADDR_W(32), .DATA_W(32)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .victim_way(victim_way), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_cold(resp_cold), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  function automatic logic [31:0] wd(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  function automatic logic [8*BB-1:0] blk(input logic [31:0] a);
    logic [8*BB-1:0] r;
    logic [31:0] base;
    base = a & ~32'(BB - 1);
    r = '0;
    for (int i = 0; i < NW; i++) r[i*32 +: 32] = wd(base + 32'(4 * i));
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) m_val[s][w] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 1);
    chk(resp_valid == 1'b0, "R9", "resp_valid after reset", 32'(resp_valid), 0);
    chk(mem_req_valid == 1'b0, "R9", "mem_req after reset", 32'(mem_req_valid), 0);
  endtask

  task automatic access(input logic [31:0] a, input int vic, input int lat,
                        output bit got_hit, output bit got_cold);
    int s, eway;
    logic [31:0] t;
    bit eh, ec;
    s = int'((a / BB) % SETS);
    t = a / (BB * SETS);
    eh = 0; ec = 0; eway = vic;
    for (int w = 0; w < WAYS; w++) if (m_val[s][w] && m_tag[s][w] == t) eh = 1;
    if (!eh) begin
      for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) begin ec = 1; eway = w; end
    end

    @(negedge clk);
    req_valid = 1'b1; req_addr = a; victim_way = 1'(vic);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R5", "ready in lookup", 32'(req_ready), 0);
    chk(resp_valid == 1'b0, "R3", "no early response", 32'(resp_valid), 0);
    @(posedge clk);
    @(negedge clk);
    if (eh) begin
      chk(resp_valid && resp_hit, "R2", "hit response", {30'd0, resp_valid, resp_hit}, 3);
      chk(resp_data == wd(a & ~32'd3), "R3", "hit data", resp_data, wd(a & ~32'd3));
      chk(mem_req_valid == 1'b0, "R2", "no fetch on hit", 32'(mem_req_valid), 0);
    end else begin
      chk(resp_valid == 1'b0, "R4", "no response before fill", 32'(resp_valid), 0);
      chk(mem_req_valid == 1'b1, "R4", "fetch raised", 32'(mem_req_valid), 1);
      chk(mem_req_addr == (a & ~32'(BB - 1)), "R4", "fetch address", mem_req_addr,
          a & ~32'(BB - 1));
      for (int i = 0; i < lat; i++) begin
        @(posedge clk);
        @(negedge clk);
        chk(mem_req_valid && !req_ready, "R4", "fetch held, ready low",
            {30'd0, mem_req_valid, req_ready}, 2);
      end
      mem_resp_valid = 1'b1;
      mem_resp_data  = blk(a);
      @(posedge clk);
      @(negedge clk);
      mem_resp_valid = 1'b0;
      chk(resp_valid && !resp_hit, "R11", "miss response", {30'd0, resp_valid, resp_hit}, 2);
      chk(resp_data == wd(a & ~32'd3), "R11", "fill data", resp_data, wd(a & ~32'd3));
      chk(resp_cold == ec, ec ? "R7" : "R8", "cold flag", 32'(resp_cold), 32'(ec));
      chk(mem_req_valid == 1'b0, "R4", "fetch dropped", 32'(mem_req_valid), 0);
      m_val[s][eway] = 1;
      m_tag[s][eway] = t;
    end
    chk(req_ready == 1'b1, "R5", "ready after response", 32'(req_ready), 1);
    got_hit = resp_hit;
    got_cold = resp_cold;
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    bit h, c;
    logic [31:0] seq [5];
    bit exp_h [5];
    logic [31:0] lfsr;
    seq = '{32'd4, 32'd0, 32'd8, 32'd36, 32'd0};
    exp_h = '{0, 1, 0, 0, 1};
    model_reset();
    repeat (3) @(posedge clk);
    do_reset();

    // R10 worked example
    for (int i = 0; i < 5; i++) begin
      access(seq[i], 0, i, h, c);
      chk(h == exp_h[i], "R10", "example hit pattern", 32'(h), 32'(exp_h[i]));
      if (i == 3) chk(c == 1'b1, "R10", "36 fills free way", 32'(c), 1);
    end
    // R6 other word of filled block hits
    access(32'd12, 0, 0, h, c);
    chk(h == 1'b1, "R6", "neighbour word hits", 32'(h), 1);
    // R8 evict way 1 (holding 36), then 36 misses while 0 still hits
    access(32'd68, 1, 2, h, c);
    chk(!h && !c, "R8", "replacement miss", {30'd0, h, c}, 0);
    access(32'd0, 0, 0, h, c);
    chk(h == 1'b1, "R10", "way 0 kept block 0", 32'(h), 1);
    access(32'd36, 0, 1, h, c);
    chk(!h, "R10", "36 was in way 1", 32'(h), 0);
    // R1 tag bits above index separate lines
    access(32'h8000_0044, 1, 0, h, c);
    chk(!h, "R1", "upper tag bit differs", 32'(h), 0);
    access(32'h8000_0040, 0, 0, h, c);
    chk(h, "R1", "same tag same block", 32'(h), 1);
    // R9 reset empties the cache
    do_reset();
    access(32'h8000_0040, 0, 0, h, c);
    chk(!h && c, "R9", "cold after reset", {30'd0, h, c}, 1);

    // mixed traffic against the model
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      access({lfsr[20], 25'd0, lfsr[5:0]}, int'(lfsr[9]), int'(lfsr[12:11]), h, c);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule